// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Model

This block models a small byte-addressed serial EEPROM as it appears on an SPI bus in mode 0. SCK idles low, and data move MSB first. The slave samples MOSI on rising SCK edges and changes MISO after falling edges. The SPI pins are brought into the block's own clock domain through a parameterised synchronizer. Each frame between a falling and a rising chip select carries a one-byte opcode. Commands that need an address take it in the next byte.

The model holds the array contents in registers. It keeps a write-enable latch and a status byte with a busy flag and two stored protect bits. A write may hold any number of data bytes, and they wrap inside one page. Reads stream on as long as the master keeps clocking. After each accepted write or status write, the model stays busy for a set number of system clock cycles. While it is busy, only the status query gets a reply.

Top module: `eeprom_spi_slave`

## Requirements
- R1: After reset the status byte reads 0x00, every memory byte reads 0x00, and MISO sits at its idle level.
- R2: Bits are exchanged MSB first in mode 0. Opcode 0x05 returns the status byte {4'b0, prot1, prot0, wel, busy} (busy in bit 0, wel in bit 1, protect bits in bits 3:2) in every byte slot after the opcode.
- R3: Opcode 0x06 sets wel when chip select rises at the end of that frame. Opcode 0x04 clears wel.
- R4: Opcodes 0x02 (write) and 0x01 (status write) are ignored while wel is clear: memory and status stay unchanged and busy does not rise.
- R5: Write (0x02) takes an address byte, of which only the low log2(MEM_BYTES) bits are used. The data bytes that follow are stored from that address upward.
- R6: Write data that run past the end of a PAGE_BYTES-aligned page wrap to the first byte of the same page.
- R7: When chip select rises after an accepted write or status write, busy is set for BUSY_CYCLES clock cycles and wel is cleared.
- R8: While busy is set, every opcode except 0x05 is ignored: a write-enable leaves wel clear, a write stores nothing, and a read returns 0x00 bytes.
- R9: Read (0x03) returns 0x00 during the address slot. It then returns memory bytes from the given address, incrementing and wrapping from the last address to 0.
- R10: Status write (0x01) copies bits 3:2 of its data byte into the protect bits. The remaining bits of the byte are dropped.
- R11: MISO is driven by the data path only while chip select is low. Otherwise it holds the MISO_IDLE value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |

## Verification
The bench builds the block with 128 bytes, 8-byte pages, two synchronizer stages and a busy time of 1000 cycles. The busy time is long enough that several complete SPI frames fit inside one busy window, so the ignored commands of R8 and the busy status of R7 can be observed through ordinary status and read frames. The small page size puts the page wrap of R6 within reach of a four-byte write. The 128-byte depth makes the read wrap at the top of the array, and the masking of the address byte's top bit, reachable with single frames.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

   localparam logic [7:0] OPC_WREN  = 8'h06;
   localparam logic [7:0] OPC_WRDI  = 8'h04;
   localparam logic [7:0] OPC_RDSR  = 8'h05;
   localparam logic [7:0] OPC_WRSR  = 8'h01;
   localparam logic [7:0] OPC_READ  = 8'h03;
   localparam logic [7:0] OPC_WRITE = 8'h02;

   localparam int unsigned BYTE_BITS = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_OPC,
      ST_WREN,
      ST_RDSR,
      ST_WRSR,
      ST_WRSR_DONE,
      ST_RD_ADDR,
      ST_RD_DATA,
      ST_WR_ADDR,
      ST_WR_DATA,
      ST_IGNORE
   } cmd_state_e;

   function automatic logic [7:0] pack_status(input logic busy,
                                              input logic wel,
                                              input logic [1:0] prot);
      return {4'b0000, prot, wel, busy};
   endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic mosi,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_act,
   output logic cs_fall_p,
   output logic cs_rise_p,
   output logic mosi_s
);

   localparam int unsigned CHAIN_W = 3 * SYNC_STAGES;
   localparam logic [2:0]  IDLE_PINS = 3'b010;

   if (SYNC_STAGES < 1) begin : g_bad_stages
      $error("spi_pin_sync: SYNC_STAGES must be at least 1");
   end

   logic [CHAIN_W-1:0] chain;
   logic [2:0]         pins_s;
   logic               sck_q;
   logic               cs_q;

   if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= IDLE_PINS;
         else        chain <= {sck, cs_n, mosi};
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {SYNC_STAGES{IDLE_PINS}};
         else        chain <= {chain[CHAIN_W-4:0], sck, cs_n, mosi};
      end
   end

   assign pins_s = chain[CHAIN_W-1 -: 3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= pins_s[2];
         cs_q  <= pins_s[1];
      end
   end

   assign mosi_s    = pins_s[0];
   assign cs_act    = ~pins_s[1];
   assign cs_fall_p = ~pins_s[1] & cs_q;
   assign cs_rise_p = pins_s[1] & ~cs_q;
   assign sck_rise  = pins_s[2] & ~sck_q;
   assign sck_fall  = ~pins_s[2] & sck_q;

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
   import eeprom_spi_pkg::*;
#(
   parameter logic MISO_IDLE = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_rise,
   input  logic       sck_fall,
   input  logic       cs_act,
   input  logic       cs_fall_p,
   input  logic       mosi_s,
   input  logic [7:0] tx_data,
   output logic       byte_done,
   output logic [7:0] rx_byte,
   output logic       tx_load,
   output logic       miso
);

   localparam int unsigned CNT_W = $clog2(BYTE_BITS);

   logic [CNT_W-1:0] bit_cnt;
   logic [7:0]       rx_sh;
   logic [7:0]       tx_sh;
   logic             last_bit;

   assign last_bit = (bit_cnt == CNT_W'(BYTE_BITS - 1));
   assign tx_load  = cs_act & sck_fall & (bit_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         byte_done <= 1'b0;
         rx_byte   <= '0;
      end else begin
         byte_done <= 1'b0;
         if (cs_fall_p) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
         end else if (cs_act) begin
            if (sck_rise) begin
               rx_sh <= {rx_sh[6:0], mosi_s};
               if (last_bit) begin
                  bit_cnt   <= '0;
                  byte_done <= 1'b1;
                  rx_byte   <= {rx_sh[6:0], mosi_s};
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            if (tx_load) begin
               tx_sh <= tx_data;
            end else if (sck_fall) begin
               tx_sh <= {tx_sh[6:0], 1'b0};
            end
         end
      end
   end

   assign miso = cs_act ? tx_sh[7] : MISO_IDLE;

   // a completed byte is reported for exactly one cycle (R2)
   p_byte_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);

   // a new transmit byte is only taken at a byte boundary, never mid-byte (R2)
   p_load_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && cs_act) |-> (bit_cnt == '0));

endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
   import eeprom_spi_pkg::*;
#(
   parameter int unsigned MEM_BYTES   = 128,
   parameter int unsigned PAGE_BYTES  = 8,
   parameter int unsigned BUSY_CYCLES = 5000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_fall_p,
   input  logic       cs_rise_p,
   input  logic       byte_done,
   input  logic [7:0] rx_byte,
   input  logic       tx_load,
   output logic [7:0] tx_data
);

   localparam int unsigned AW = $clog2(MEM_BYTES);
   localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);
   localparam logic [AW-1:0] PAGE_MASK = AW'(PAGE_BYTES - 1);

   if ((MEM_BYTES < 2) || (MEM_BYTES > 256) ||
       ((MEM_BYTES & (MEM_BYTES - 1)) != 0)) begin : g_bad_mem
      $error("eeprom_cmd_ctrl: MEM_BYTES must be a power of two in 2..256");
   end
   if ((PAGE_BYTES < 2) || (PAGE_BYTES > MEM_BYTES) ||
       ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0)) begin : g_bad_page
      $error("eeprom_cmd_ctrl: PAGE_BYTES must be a power of two within the array");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("eeprom_cmd_ctrl: BUSY_CYCLES must be at least 1");
   end

   cmd_state_e    state;
   logic [7:0]    mem [MEM_BYTES];
   logic [AW-1:0] rd_ptr;
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] wr_next;
   logic [CW-1:0] busy_cnt;
   logic          busy;
   logic          wel;
   logic [1:0]    prot;
   logic          mem_we;
   logic          commit;

   assign busy    = (busy_cnt != '0);
   assign mem_we  = byte_done && (state == ST_WR_DATA);
   assign wr_next = (wr_ptr & ~PAGE_MASK) | ((wr_ptr + 1'b1) & PAGE_MASK);
   assign commit  = (state == ST_WR_ADDR) || (state == ST_WR_DATA) ||
                    (state == ST_WRSR)    || (state == ST_WRSR_DONE);

   // command sequencing, write-enable latch, protect bits and busy timer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         rd_ptr   <= '0;
         wr_ptr   <= '0;
         busy_cnt <= '0;
         wel      <= 1'b0;
         prot     <= 2'b00;
      end else begin
         if (busy) busy_cnt <= busy_cnt - 1'b1;

         if (cs_fall_p) begin
            state <= ST_OPC;
         end else if (cs_rise_p) begin
            if (state == ST_WREN) wel <= 1'b1;
            if (commit) begin
               wel      <= 1'b0;
               busy_cnt <= CW'(BUSY_CYCLES);
            end
            state <= ST_IDLE;
         end else if (byte_done) begin
            unique case (state)
               ST_OPC: begin
                  if (busy && (rx_byte != OPC_RDSR)) begin
                     state <= ST_IGNORE;
                  end else begin
                     case (rx_byte)
                        OPC_WREN:  state <= ST_WREN;
                        OPC_WRDI: begin
                           wel   <= 1'b0;
                           state <= ST_IGNORE;
                        end
                        OPC_RDSR:  state <= ST_RDSR;
                        OPC_WRSR:  state <= wel ? ST_WRSR : ST_IGNORE;
                        OPC_READ:  state <= ST_RD_ADDR;
                        OPC_WRITE: state <= wel ? ST_WR_ADDR : ST_IGNORE;
                        default:   state <= ST_IGNORE;
                     endcase
                  end
               end
               ST_RD_ADDR: begin
                  rd_ptr <= rx_byte[AW-1:0];
                  state  <= ST_RD_DATA;
               end
               ST_WR_ADDR: begin
                  wr_ptr <= rx_byte[AW-1:0];
                  state  <= ST_WR_DATA;
               end
               ST_WR_DATA: begin
                  wr_ptr <= wr_next;
               end
               ST_WRSR: begin
                  prot  <= rx_byte[3:2];
                  state <= ST_WRSR_DONE;
               end
               ST_WREN: begin
                  state <= ST_IGNORE;
               end
               default: ;
            endcase
         end

         if (tx_load && (state == ST_RD_DATA)) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
      end
   end

   // storage array, written one data byte at a time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
      end else if (mem_we) begin
         mem[wr_ptr] <= rx_byte;
      end
   end

   always_comb begin
      unique case (state)
         ST_RDSR:    tx_data = pack_status(busy, wel, prot);
         ST_RD_DATA: tx_data = mem[rd_ptr];
         default:    tx_data = 8'h00;
      endcase
   end

   // nothing reaches the array while the programming timer runs (R8)
   p_no_store_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !mem_we);

   // a non-status opcode seen while busy leads to the ignore state (R8)
   p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && (state == ST_OPC) && busy && (rx_byte != OPC_RDSR))
      |=> (state == ST_IGNORE));

   // entering busy drops the write-enable latch (R7)
   p_wel_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !wel);

   // busy window starts at its full length (R7)
   p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (busy_cnt == CW'(BUSY_CYCLES)));

   // stored data never leave the page of the write address (R6)
   p_page_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> ((wr_ptr & ~PAGE_MASK) == $past(wr_ptr & ~PAGE_MASK)));

   // a write or status write needs the latch to have been set (R4)
   p_need_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && (state == ST_OPC) && !wel &&
       ((rx_byte == OPC_WRITE) || (rx_byte == OPC_WRSR))) |=> (state == ST_IGNORE));

endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave #(
   parameter int unsigned MEM_BYTES   = 128,
   parameter int unsigned PAGE_BYTES  = 8,
   parameter int unsigned BUSY_CYCLES = 5000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        MISO_IDLE   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic mosi,
   output logic miso
);

   logic       sck_rise;
   logic       sck_fall;
   logic       cs_act;
   logic       cs_fall_p;
   logic       cs_rise_p;
   logic       mosi_s;
   logic       byte_done;
   logic [7:0] rx_byte;
   logic       tx_load;
   logic [7:0] tx_data;

   spi_pin_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck      (sck),
      .cs_n     (cs_n),
      .mosi     (mosi),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .cs_act   (cs_act),
      .cs_fall_p(cs_fall_p),
      .cs_rise_p(cs_rise_p),
      .mosi_s   (mosi_s)
   );

   spi_byte_shifter #(
      .MISO_IDLE(MISO_IDLE)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .cs_act   (cs_act),
      .cs_fall_p(cs_fall_p),
      .mosi_s   (mosi_s),
      .tx_data  (tx_data),
      .byte_done(byte_done),
      .rx_byte  (rx_byte),
      .tx_load  (tx_load),
      .miso     (miso)
   );

   eeprom_cmd_ctrl #(
      .MEM_BYTES  (MEM_BYTES),
      .PAGE_BYTES (PAGE_BYTES),
      .BUSY_CYCLES(BUSY_CYCLES)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_fall_p(cs_fall_p),
      .cs_rise_p(cs_rise_p),
      .byte_done(byte_done),
      .rx_byte  (rx_byte),
      .tx_load  (tx_load),
      .tx_data  (tx_data)
   );

   // with chip select high long enough to pass the synchronizer, MISO idles (R11)
   p_miso_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs_n) && cs_n && !cs_act) |-> (miso == MISO_IDLE));

endmodule

// File: tb/tb_eeprom_spi_slave.sv
module tb_eeprom_spi_slave;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int BUSY       = 1000;
   localparam int BUSY_WAIT  = 1200;

   // {write address, data, read-back address}
   localparam logic [23:0] VEC [5] = '{
      {8'h00, 8'hA5, 8'h00},
      {8'h07, 8'h3C, 8'h07},
      {8'h10, 8'hFF, 8'h10},
      {8'h7F, 8'h81, 8'h7F},
      {8'h85, 8'h5A, 8'h05}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0;
   logic cs_n = 1'b1;
   logic mosi = 1'b0;
   logic miso;

   int checks = 0;
   int errors = 0;
   logic [7:0] tx_buf [16];
   logic [7:0] rx_buf [16];

   always #(CLK_PERIOD / 2) clk = ~clk;

   eeprom_spi_slave #(
      .MEM_BYTES  (128),
      .PAGE_BYTES (8),
      .BUSY_CYCLES(BUSY),
      .SYNC_STAGES(2),
      .MISO_IDLE  (1'b0)
   ) dut (
      .clk  (clk),
      .rst_n(rst_n),
      .sck  (sck),
      .cs_n (cs_n),
      .mosi (mosi),
      .miso (miso)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   task automatic spi_frame(input int n);
      cs_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < n; i++) begin
         for (int b = 7; b >= 0; b--) begin
            mosi = tx_buf[i][b];
            wait_clk(HALF);
            rx_buf[i][b] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
         end
      end
      wait_clk(HALF);
      cs_n = 1'b1;
      mosi = 1'b0;
      wait_clk(2 * HALF);
   endtask

   task automatic cmd1(input logic [7:0] op);
      tx_buf[0] = op;
      spi_frame(1);
   endtask

   task automatic read_status(output logic [7:0] st);
      tx_buf[0] = 8'h05;
      tx_buf[1] = 8'h00;
      spi_frame(2);
      st = rx_buf[1];
   endtask

   task automatic write_bytes(input logic [7:0] addr, input int n,
                              input logic [7:0] d0, input logic [7:0] d1,
                              input logic [7:0] d2, input logic [7:0] d3);
      tx_buf[0] = 8'h02;
      tx_buf[1] = addr;
      tx_buf[2] = d0;
      tx_buf[3] = d1;
      tx_buf[4] = d2;
      tx_buf[5] = d3;
      spi_frame(2 + n);
   endtask

   task automatic read_bytes(input logic [7:0] addr, input int n);
      tx_buf[0] = 8'h03;
      tx_buf[1] = addr;
      for (int i = 2; i < 2 + n; i++) tx_buf[i] = 8'h00;
      spi_frame(2 + n);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] st;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R1 / R11: reset state
      check("R11 idle miso after reset", {7'b0, miso}, 8'h00);
      read_status(st);
      check("R1 status after reset", st, 8'h00);
      read_bytes(8'h20, 2);
      check("R1 memory after reset", rx_buf[2], 8'h00);
      check("R1 memory after reset next", rx_buf[3], 8'h00);
      check("R9 address slot returns zero", rx_buf[1], 8'h00);

      // R2 / R5 / R7: table walk of single-byte writes and read-backs
      foreach (VEC[k]) begin
         cmd1(8'h06);
         write_bytes(VEC[k][23:16], 1, VEC[k][15:8], 8'h00, 8'h00, 8'h00);
         read_status(st);
         check("R7 busy set, wel cleared", st, 8'h01);
         wait_clk(BUSY_WAIT);
         read_status(st);
         check("R7 busy cleared", st, 8'h00);
         read_bytes(VEC[k][7:0], 1);
         check("R5 data read back", rx_buf[2], VEC[k][15:8]);
      end

      // R2 / R3: latch set by 0x06 shows in every slot, cleared by 0x04
      cmd1(8'h06);
      tx_buf[0] = 8'h05; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
      spi_frame(3);
      check("R3 wel set", rx_buf[1], 8'h02);
      check("R2 status repeats", rx_buf[2], 8'h02);
      check("R2 opcode slot", rx_buf[0], 8'h00);
      cmd1(8'h04);
      read_status(st);
      check("R3 wel cleared", st, 8'h00);

      // R4: write without latch
      write_bytes(8'h30, 1, 8'h77, 8'h00, 8'h00, 8'h00);
      read_status(st);
      check("R4 no busy without wel", st, 8'h00);
      read_bytes(8'h30, 1);
      check("R4 memory untouched", rx_buf[2], 8'h00);
      tx_buf[0] = 8'h01; tx_buf[1] = 8'h0C;
      spi_frame(2);
      read_status(st);
      check("R4 status write ignored", st, 8'h00);

      // R6: four bytes from 0x46 wrap inside page 0x40..0x47
      cmd1(8'h06);
      write_bytes(8'h46, 4, 8'h11, 8'h22, 8'h33, 8'h44);
      wait_clk(BUSY_WAIT);
      read_bytes(8'h40, 8);
      check("R6 wrap byte 0x40", rx_buf[2], 8'h33);
      check("R6 wrap byte 0x41", rx_buf[3], 8'h44);
      check("R6 untouched 0x42", rx_buf[4], 8'h00);
      check("R6 untouched 0x45", rx_buf[7], 8'h00);
      check("R6 first byte 0x46", rx_buf[8], 8'h11);
      check("R6 second byte 0x47", rx_buf[9], 8'h22);
      read_bytes(8'h48, 1);
      check("R6 next page untouched", rx_buf[2], 8'h00);

      // R8: commands during busy
      cmd1(8'h06);
      write_bytes(8'h50, 1, 8'h99, 8'h00, 8'h00, 8'h00);
      cmd1(8'h06);
      read_status(st);
      check("R8 write enable ignored while busy", st, 8'h01);
      read_bytes(8'h50, 1);
      check("R8 read ignored while busy", rx_buf[2], 8'h00);
      wait_clk(BUSY_WAIT);
      read_bytes(8'h50, 1);
      check("R8 first write kept", rx_buf[2], 8'h99);

      // R9: sequential read wraps from the top address to zero
      read_bytes(8'h7E, 4);
      check("R9 byte 0x7E", rx_buf[2], 8'h00);
      check("R9 byte 0x7F", rx_buf[3], 8'h81);
      check("R9 wrap to 0x00", rx_buf[4], 8'hA5);
      check("R9 byte 0x01", rx_buf[5], 8'h00);

      // R10: status write keeps only the protect bits
      cmd1(8'h06);
      tx_buf[0] = 8'h01; tx_buf[1] = 8'hFF;
      spi_frame(2);
      read_status(st);
      check("R10 protect bits while busy", st, 8'h0D);
      wait_clk(BUSY_WAIT);
      read_status(st);
      check("R10 protect bits stored", st, 8'h0C);

      // R11: idle level between frames
      wait_clk(4);
      check("R11 idle miso between frames", {7'b0, miso}, 8'h00);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule